// File: doc/BRIEF.md
# Pulse-Count Current-Limit Decoder

This block reads a single-wire enable line that is also used to program the peak switch current of a flash charger. While the line is low the block sits idle and drives all of its outputs to zero. When the line rises, a programming burst begins. The first high pulse must be long. After it, short pulses may follow. The block counts rising edges inside a fixed window timed from the first edge. When a longer setup interval ends, it latches one of eight current-limit levels and raises a ready flag that allows power switching to start.

The level stays in force for as long as the line stays high. Pulling the line low clears the setting and re-arms the decoder for a new burst. Every time window is given in nanoseconds and converted to clock cycles from the clock-frequency parameter. The line goes through a two-flop synchronizer before any edge is detected, so the edge offsets below are counted in clock cycles from the first edge as seen after that synchronizer.

Top module: `pcl_decoder`

## Requirements
- R1: The level code k (0..7) maps to pct_o as follows: 0→100, 1→93, 2→86, 3→79, 4→71, 5→64, 6→57, 7→50. The formula is 100 − round(50·k/7).
- R2: The first rising edge starts a burst. A burst of N counted rising edges gives level_o = N−1. A single edge with no further pulses gives code 0, which is 100 percent.
- R3: Counting saturates at 8 edges. Extra edges inside the window leave code 7.
- R4: If the line falls before the first high pulse has lasted FIRST_NS (FIRST_CYC cycles), the burst is dropped. The block returns to idle, and ready_o, level_o and pct_o stay 0. A first pulse of exactly FIRST_CYC cycles is accepted.
- R5: An edge is counted when its offset from the first edge is below WINDOW_NS (WIN_CYC cycles). An edge at offset WIN_CYC−1 is counted. An edge at offset WIN_CYC or later is ignored.
- R6: ready_o rises on the clock edge SETUP_CYC+1 edges after the clock edge that captures the first rise of line_i. It rises only if the synchronized line is high in the last setup cycle. If the line is low at that point, the block returns to idle.
- R7: While ready_o is high and the line stays high, level_o and pct_o do not change.
- R8: A low line clears ready_o, level_o and pct_o by the third clock edge after line_i falls. The next rising edge then starts a new burst.
- R9: High and low phases of one clock cycle each are counted as separate edges.
- R10: With rst_ni low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous enable / programming line |
| level_o | output | LEVEL_W (3) | Selected current-limit code, 0 = 100 percent |
| pct_o | output | 7 | Percentage of the default current for the selected code |
| ready_o | output | 1 | Setting valid; switching may begin |

## Verification
The bench builds the decoder with CLK_FREQ_HZ set to 2 MHz while it still toggles a 125 MHz clock. This turns the 15, 40 and 45 µs windows into 30, 80 and 90 cycles. At that size a bench can place an edge exactly one cycle inside or outside the counting window, and one cycle short of or at the minimum first-pulse width. It can also check the exact cycle in which ready_o rises, all within a few hundred cycles per burst. Every one of the eight levels, the saturation at eight edges, and bursts with one-cycle phases fit in the vector table.

// File: rtl/pcl_pkg.sv
`timescale 1ns/1ps
package pcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_COUNT,
    ST_SETUP,
    ST_READY
  } pcl_state_e;

  function automatic int unsigned ns_to_cyc(longint unsigned f_hz, longint unsigned ns);
    longint unsigned c;
    c = (f_hz * ns) / 64'd1_000_000_000;
    return int'(c);
  endfunction

  // percent of default for code k, evenly stepped from 100 down to min_pct
  function automatic int unsigned level_pct(int unsigned k, int unsigned levels,
                                            int unsigned min_pct);
    if (levels < 2) return 100;
    return 100 - (((100 - min_pct) * k + (levels - 1) / 2) / (levels - 1));
  endfunction

endpackage

// File: rtl/pcl_sync.sv
`timescale 1ns/1ps
module pcl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9

endmodule

// File: rtl/pcl_burst_fsm.sv
`timescale 1ns/1ps
module pcl_burst_fsm
  import pcl_pkg::*;
#(
  parameter int unsigned FIRST_CYC = 30,
  parameter int unsigned WIN_CYC   = 80,
  parameter int unsigned SETUP_CYC = 90,
  parameter int unsigned LEVELS    = 8,
  parameter int unsigned CNT_W     = $clog2(LEVELS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic             rise_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned TW = $clog2(SETUP_CYC + 1);
  localparam logic [TW-1:0]    FIRST_LAST = TW'(FIRST_CYC - 1);
  localparam logic [TW-1:0]    WIN_LAST   = TW'(WIN_CYC - 1);
  localparam logic [TW-1:0]    SETUP_LAST = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0]    SETUP_END  = TW'(SETUP_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(LEVELS);

  pcl_state_e       state_q;
  logic [TW-1:0]    tmr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          cnt_q <= '0;
          if (rise_i) begin
            state_q <= ST_FIRST;
            tmr_q   <= TW'(1);
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_FIRST: begin
          if (!level_i) begin
            // first pulse too short: drop the burst
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            cnt_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
            if (tmr_q >= FIRST_LAST) state_q <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          tmr_q <= tmr_q + TW'(1);
          if (rise_i && cnt_q < CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
          if (tmr_q >= WIN_LAST) state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tmr_q >= SETUP_LAST) begin
            if (level_i) begin
              state_q <= ST_READY;
              tmr_q   <= SETUP_END;
            end else begin
              state_q <= ST_IDLE;
              tmr_q   <= '0;
              cnt_q   <= '0;
            end
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_READY: begin
          if (!level_i) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            cnt_q   <= '0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          tmr_q   <= '0;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign ready_o = (state_q == ST_READY);
  assign cnt_o   = cnt_q;

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R3
  AST_READY_AT_SETUP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY) |-> (tmr_q == SETUP_END)); // R6
  AST_FIRST_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && $past(state_q) == ST_FIRST) |-> $past(level_i)); // R4
  AST_READY_HAS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY) |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/pcl_level_map.sv
`timescale 1ns/1ps
module pcl_level_map
  import pcl_pkg::*;
#(
  parameter int unsigned LEVELS  = 8,
  parameter int unsigned MIN_PCT = 50,
  parameter int unsigned CNT_W   = $clog2(LEVELS + 1),
  parameter int unsigned LEVEL_W = $clog2(LEVELS)
) (
  input  logic               valid_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic [6:0]         pct_o
);

  logic [6:0] pct_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_tab
    assign pct_tab[g] = 7'(level_pct(g, LEVELS, MIN_PCT));
  end

  logic [CNT_W-1:0]   idx;
  logic [LEVEL_W-1:0] code;

  assign idx  = cnt_i - CNT_W'(1);
  assign code = LEVEL_W'(idx);

  always_comb begin
    level_o = '0;
    pct_o   = '0;
    if (valid_i && cnt_i != '0) begin
      level_o = code;
      pct_o   = pct_tab[code];
    end
  end

endmodule

// File: rtl/pcl_decoder.sv
`timescale 1ns/1ps
module pcl_decoder
  import pcl_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 125_000_000,
  parameter longint unsigned FIRST_NS    = 15_000,
  parameter longint unsigned WINDOW_NS   = 40_000,
  parameter longint unsigned SETUP_NS    = 45_000,
  parameter int unsigned     LEVELS      = 8,
  parameter int unsigned     MIN_PCT     = 50,
  parameter int unsigned     LEVEL_W     = $clog2(LEVELS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic [6:0]         pct_o,
  output logic               ready_o
);

  localparam int unsigned FIRST_CYC = ns_to_cyc(CLK_FREQ_HZ, FIRST_NS);
  localparam int unsigned WIN_CYC   = ns_to_cyc(CLK_FREQ_HZ, WINDOW_NS);
  localparam int unsigned SETUP_CYC = ns_to_cyc(CLK_FREQ_HZ, SETUP_NS);
  localparam int unsigned CNT_W     = $clog2(LEVELS + 1);

  logic             sync_level;
  logic             sync_rise;
  logic             fsm_ready;
  logic [CNT_W-1:0] edge_cnt;

  pcl_sync #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .level_o (sync_level),
    .rise_o  (sync_rise)
  );

  pcl_burst_fsm #(
    .FIRST_CYC (FIRST_CYC),
    .WIN_CYC   (WIN_CYC),
    .SETUP_CYC (SETUP_CYC),
    .LEVELS    (LEVELS),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (sync_level),
    .rise_i  (sync_rise),
    .ready_o (fsm_ready),
    .cnt_o   (edge_cnt)
  );

  pcl_level_map #(
    .LEVELS  (LEVELS),
    .MIN_PCT (MIN_PCT),
    .CNT_W   (CNT_W),
    .LEVEL_W (LEVEL_W)
  ) u_map (
    .valid_i (fsm_ready),
    .cnt_i   (edge_cnt),
    .level_o (level_o),
    .pct_o   (pct_o)
  );

  assign ready_o = fsm_ready;

  AST_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_level |=> !ready_o); // R8
  AST_SETTING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> ($stable(level_o) && $stable(pct_o))); // R7
  AST_PCT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (pct_o >= 7'(MIN_PCT) && pct_o <= 7'd100)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (level_o == '0 && pct_o == '0)); // R8

endmodule

// File: tb/tb_pcl_decoder.sv
`timescale 1ns/1ps
module tb_pcl_decoder;

  localparam int SETUP_CYC = 90;
  localparam int NV = 10;

  typedef struct packed {
    int w1; int n; int lo; int hi; int code; int pct;
  } vec_t;

  // first width, extra pulses, low width, high width, code, percent
  localparam vec_t VECS [NV] = '{
    '{40, 0,  0, 0, 0, 100},  // R2 single edge
    '{30, 3,  2, 2, 3, 79},   // R2
    '{30, 7,  1, 1, 7, 50},   // R9 one-cycle phases
    '{30, 10, 1, 1, 7, 50},   // R3 saturation
    '{30, 1, 49, 0, 1, 93},   // R5 edge at 79 counted
    '{30, 1, 50, 0, 0, 100},  // R5 edge at 80 ignored
    '{35, 5,  3, 4, 5, 64},   // R1
    '{50, 2,  5, 5, 2, 86},   // R1
    '{30, 4,  1, 3, 4, 71},   // R1
    '{30, 6,  2, 2, 6, 57}    // R1
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b0;
  logic [2:0] level_o;
  logic [6:0] pct_o;
  logic       ready_o;

  int n_tests = 0;
  int n_fail  = 0;
  int elapsed = 0;

  always #4 clk_i = ~clk_i;

  pcl_decoder #(.CLK_FREQ_HZ(2_000_000)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .level_o (level_o),
    .pct_o   (pct_o),
    .ready_o (ready_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    elapsed += n;
  endtask

  task automatic wait_to(input int target);
    if (target > elapsed) step(target - elapsed);
  endtask

  task automatic burst(input int w1, input int n, input int lo, input int hi);
    elapsed = 0;
    line_i = 1'b1;
    step(w1);
    for (int k = 0; k < n; k++) begin
      line_i = 1'b0;
      step(lo);
      line_i = 1'b1;
      if (k < n - 1) step(hi);
    end
  endtask

  task automatic check_clear(input string req);
    chk(req, int'(ready_o), 0);
    chk(req, int'(level_o), 0);
    chk(req, int'(pct_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk_i);
    check_clear("R10");
    rst_ni = 1'b1;
    step(5);
    check_clear("R10");

    for (int v = 0; v < NV; v++) begin
      burst(VECS[v].w1, VECS[v].n, VECS[v].lo, VECS[v].hi);
      wait_to(SETUP_CYC + 10);
      chk($sformatf("R2 vec%0d ready", v), int'(ready_o), 1);
      chk($sformatf("R1 vec%0d code", v), int'(level_o), VECS[v].code);
      chk($sformatf("R1 vec%0d pct", v), int'(pct_o), VECS[v].pct);
      line_i = 1'b0;
      step(3);
      check_clear($sformatf("R8 vec%0d", v));
      step(7);
    end

    // R6 exact ready cycle, then R7 hold, then R8 clear latency
    burst(30, 2, 1, 1);
    wait_to(SETUP_CYC + 1);
    chk("R6 early", int'(ready_o), 0);
    step(1);
    chk("R6 on time", int'(ready_o), 1);
    chk("R6 code", int'(level_o), 2);
    step(300);
    chk("R7 ready held", int'(ready_o), 1);
    chk("R7 code held", int'(level_o), 2);
    chk("R7 pct held", int'(pct_o), 86);
    line_i = 1'b0;
    step(2);
    chk("R8 not yet", int'(ready_o), 1);
    step(1);
    check_clear("R8 third edge");
    step(10);

    // R4 first pulse one cycle short
    burst(29, 0, 0, 0);
    line_i = 1'b0;
    step(150);
    check_clear("R4 short first");
    // R4 boundary width accepted, then extra edge counted
    burst(30, 1, 5, 0);
    wait_to(SETUP_CYC + 5);
    chk("R4 boundary ready", int'(ready_o), 1);
    chk("R4 boundary code", int'(level_o), 1);
    line_i = 1'b0;
    step(10);

    // R6 line low at end of setup: no ready, then new burst accepted
    burst(30, 1, 70, 0);
    line_i = 1'b1;
    chk("R6 low at setup end", int'(ready_o), 0);
    chk("R6 low code", int'(level_o), 0);
    elapsed = 0;
    wait_to(SETUP_CYC + 5);
    chk("R8 rearm ready", int'(ready_o), 1);
    chk("R8 rearm pct", int'(pct_o), 100);

    // R10 reset while ready
    rst_ni = 1'b0;
    step(2);
    check_clear("R10 mid");
    rst_ni = 1'b1;
    line_i = 1'b0;
    step(5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule